// File: doc/BRIEF.md
# Sample-Rate Tracker and Domain Selector

This block recovers the rate of an incoming audio stream from nothing but a strobe that pulses once per arriving sample. It counts reference-clock cycles between strobes and feeds each count into a first-order tracking loop that smooths out arrival jitter. Once enough consecutive counts agree with the estimate, the block declares lock. While locked it generates a clean sample tick. The tick is paced by the smoothed estimate and not by the raw strobes.

The smoothed period is also sorted into one of four rate bands, coded 0 to 3 for domains 1 to 4. Later tone-control stages use this code to pick coefficient sets. Band changes pass through a hysteresis counter so that a rate sitting near an edge does not make the code chatter. Estimates outside the legal span raise an out-of-range flag, and so does a silent input. All decisions are made from the arrivals alone; no rate value or control write is ever supplied.

The reference clock frequency is the parameter `REF_KHZ`, given in kHz. Every period threshold is derived from it by integer division.

Top module: `rate_tracker`

## Requirements
- R1: The first interval measured after reset or after a timeout seeds the estimate directly. An interval is the number of clock cycles between two successive strobes, and the strobe that opens the interval is not itself measured. So the estimate equals that interval exactly.
- R2: Each later interval m updates the estimate e to e + floor((m - e) / 16). The estimate changes on no other cycle.
- R3: An interval is in-window when |m - e| * 50 <= e, using e before the update. `rate_valid` rises after 16 consecutive in-window intervals, provided the estimate is in range. Any out-of-window interval clears lock at once. A seeding interval resets the run of agreeing intervals to zero.
- R4: The band code is computed from the estimate p with thresholds P12 = REF_KHZ/12, P25 = REF_KHZ/25 and P40 = REF_KHZ/40. The code is 3 when p <= P40, 2 when p <= P25, 1 when p <= P12, and 0 otherwise. A period exactly on an edge therefore takes the higher-rate band.
- R5: `domain` changes only after the same new band has been computed from 8 consecutive in-range estimates. An estimate that falls in the current band resets that run.
- R6: `out_of_range` is high, and `rate_valid` low, when the estimate is above REF_KHZ/5 or below REF_KHZ/55. Exactly REF_KHZ/55 is in range.
- R7: Suppose a strobe has been seen and no further strobe arrives for more than 2*(REF_KHZ/5) cycles. Then lock is cleared, `out_of_range` is set, `rate_valid` falls, and ticks stop. The next strobe starts a fresh measurement.
- R8: While locked, `sample_tick` is a one-cycle pulse repeating every `period_est` cycles. It never pulses before lock.
- R9: After a synchronous reset, `period_est` is 0, `domain` is 3, and `rate_valid`, `out_of_range` and `sample_tick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the measurement timebase |
| rst | input | 1 | Synchronous reset, active high |
| sample_strobe | input | 1 | One-cycle pulse per arriving sample |
| period_est | output | PW | Smoothed period in reference cycles |
| sample_tick | output | 1 | Regenerated sample tick |
| domain | output | 2 | Rate band code, 0..3 for domains 1..4 |
| rate_valid | output | 1 | Locked and in range |
| out_of_range | output | 1 | Estimate outside the legal span, or input silent |

## Verification
A wrong shift or a wrong seed in the loop shows up in `period_est` two cycles after the strobe that caused it. From then on it keeps diverging from an estimate computed independently from the known gaps. A miscounted lock run or hysteresis run moves the rise of `rate_valid`, or a change of `domain`, by whole strobe intervals. Directed sequences with exact periods expose these as an off-by-one sample. A silence timeout that fires late or never leaves `out_of_range` low, and ticks still present, after the idle window.

// File: rtl/rt_pkg.sv
package rt_pkg;

  function automatic logic [1:0] band_of(int unsigned p, int unsigned e12,
                                         int unsigned e25, int unsigned e40);
    if (p <= e40) return 2'd3;
    if (p <= e25) return 2'd2;
    if (p <= e12) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic outside(int unsigned p, int unsigned lo, int unsigned hi);
    return (p < lo) || (p > hi);
  endfunction

  function automatic logic near(int unsigned m, int unsigned e, int unsigned div);
    int unsigned d;
    d = (m > e) ? (m - e) : (e - m);
    return (d * div) <= e;
  endfunction

  function automatic int unsigned smooth(int unsigned m, int unsigned e, int sh);
    int d;
    d = int'(m) - int'(e);
    return $unsigned(int'(e) + (d >>> sh));
  endfunction

endpackage

// File: rtl/period_meter.sv
module period_meter #(
  parameter int PW = 14,
  parameter int TO = 9830
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  output logic          meas_evt,
  output logic [PW-1:0] meas_val,
  output logic          timeout_evt
);
  logic [PW-1:0] cnt;
  logic          have_prev;

  assign meas_evt    = strobe && have_prev;
  assign meas_val    = cnt;
  assign timeout_evt = have_prev && !strobe && (cnt == PW'(TO));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      have_prev <= 1'b0;
    end else if (strobe) begin
      cnt       <= PW'(1);
      have_prev <= 1'b1;
    end else if (timeout_evt) begin
      have_prev <= 1'b0;
    end else if (have_prev) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/period_loop.sv
module period_loop #(
  parameter int PW        = 14,
  parameter int LOCK_N    = 16,
  parameter int SMOOTH_SH = 4,
  parameter int WIN_DIV   = 50,
  parameter int P_MIN     = 446,
  parameter int P_MAX     = 4915
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          meas_evt,
  input  logic [PW-1:0] meas_val,
  input  logic          timeout_evt,
  output logic [PW-1:0] est,
  output logic          locked,
  output logic          oor,
  output logic          est_upd
);
  localparam int LW = $clog2(LOCK_N + 1);

  logic          est_valid;
  logic [LW-1:0] lcnt, lcnt_next;
  logic [PW-1:0] est_next;
  logic          in_win;

  assign in_win = rt_pkg::near(32'(meas_val), 32'(est), WIN_DIV);

  always_comb begin
    if (est_valid) est_next = PW'(rt_pkg::smooth(32'(meas_val), 32'(est), SMOOTH_SH));
    else           est_next = meas_val;
  end

  always_comb begin
    if (!est_valid)                 lcnt_next = '0;
    else if (!in_win)               lcnt_next = '0;
    else if (lcnt == LW'(LOCK_N))   lcnt_next = lcnt;
    else                            lcnt_next = lcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      est       <= '0;
      est_valid <= 1'b0;
      lcnt      <= '0;
      locked    <= 1'b0;
      oor       <= 1'b0;
      est_upd   <= 1'b0;
    end else begin
      est_upd <= meas_evt;
      if (timeout_evt) begin
        est_valid <= 1'b0;
        lcnt      <= '0;
        locked    <= 1'b0;
        oor       <= 1'b1;
      end else if (meas_evt) begin
        est       <= est_next;
        est_valid <= 1'b1;
        lcnt      <= lcnt_next;
        locked    <= (lcnt_next == LW'(LOCK_N));
        oor       <= rt_pkg::outside(32'(est_next), P_MIN, P_MAX);
      end
    end
  end
endmodule

// File: rtl/band_select.sv
module band_select #(
  parameter int PW     = 14,
  parameter int HYST_N = 8,
  parameter int P_12   = 2048,
  parameter int P_25   = 983,
  parameter int P_40   = 614
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          est_upd,
  input  logic [PW-1:0] est,
  input  logic          oor,
  input  logic          timeout_evt,
  output logic [1:0]    domain
);
  localparam int RW = $clog2(HYST_N + 1);

  logic [1:0]    cand, pend;
  logic [RW-1:0] run;

  assign cand = rt_pkg::band_of(32'(est), P_12, P_25, P_40);

  always_ff @(posedge clk) begin
    if (rst) begin
      domain <= 2'd3;
      pend   <= 2'd3;
      run    <= '0;
    end else if (timeout_evt) begin
      run <= '0;
    end else if (est_upd) begin
      if (oor || cand == domain) begin
        run <= '0;
      end else if (run != '0 && cand == pend) begin
        if (run == RW'(HYST_N - 1)) begin
          domain <= cand;
          run    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        pend <= cand;
        run  <= RW'(1);
      end
    end
  end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int PW = 14
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic [PW-1:0] est,
  output logic          tick
);
  logic [PW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst || !locked) begin
      tcnt <= '0;
      tick <= 1'b0;
    end else if (tcnt >= est - PW'(1)) begin
      tcnt <= '0;
      tick <= 1'b1;
    end else begin
      tcnt <= tcnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_tracker.sv
module rate_tracker #(
  parameter int REF_KHZ   = 24576,
  parameter int LOCK_N    = 16,
  parameter int HYST_N    = 8,
  parameter int SMOOTH_SH = 4,
  parameter int WIN_DIV   = 50,
  parameter int PW        = $clog2(2 * (REF_KHZ / 5) + 2)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_strobe,
  output logic [PW-1:0] period_est,
  output logic          sample_tick,
  output logic [1:0]    domain,
  output logic          rate_valid,
  output logic          out_of_range
);
  localparam int P_SLOW = REF_KHZ / 5;
  localparam int P_12   = REF_KHZ / 12;
  localparam int P_25   = REF_KHZ / 25;
  localparam int P_40   = REF_KHZ / 40;
  localparam int P_FAST = REF_KHZ / 55;
  localparam int TO     = 2 * P_SLOW;

  logic          meas_evt, timeout_evt, est_upd, locked;
  logic [PW-1:0] meas_val;

  period_meter #(.PW(PW), .TO(TO)) u_meter (
    .clk(clk), .rst(rst), .strobe(sample_strobe),
    .meas_evt(meas_evt), .meas_val(meas_val), .timeout_evt(timeout_evt)
  );

  period_loop #(.PW(PW), .LOCK_N(LOCK_N), .SMOOTH_SH(SMOOTH_SH),
                .WIN_DIV(WIN_DIV), .P_MIN(P_FAST), .P_MAX(P_SLOW)) u_loop (
    .clk(clk), .rst(rst), .meas_evt(meas_evt), .meas_val(meas_val),
    .timeout_evt(timeout_evt), .est(period_est), .locked(locked),
    .oor(out_of_range), .est_upd(est_upd)
  );

  band_select #(.PW(PW), .HYST_N(HYST_N), .P_12(P_12), .P_25(P_25),
                .P_40(P_40)) u_band (
    .clk(clk), .rst(rst), .est_upd(est_upd), .est(period_est),
    .oor(out_of_range), .timeout_evt(timeout_evt), .domain(domain)
  );

  tick_gen #(.PW(PW)) u_tick (
    .clk(clk), .rst(rst), .locked(locked), .est(period_est), .tick(sample_tick)
  );

  assign rate_valid = locked && !out_of_range;
endmodule

// File: rtl/rate_tracker_chk.sv
module rate_tracker_chk #(
  parameter int PW = 14
)(
  input logic          clk,
  input logic          rst,
  input logic          meas_evt,
  input logic          timeout_evt,
  input logic          est_upd,
  input logic          locked,
  input logic [PW-1:0] period_est,
  input logic [1:0]    domain,
  input logic          sample_tick,
  input logic          rate_valid,
  input logic          out_of_range
);
  // R2
  est_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !meas_evt |=> $stable(period_est));

  // R5
  domain_on_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(domain) |-> $past(est_upd));

  // R6
  valid_excludes_oor_chk: assert property (@(posedge clk) disable iff (rst)
    out_of_range |-> !rate_valid);

  // R3
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    rate_valid |-> locked);

  // R7
  silence_drop_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> (!locked && out_of_range));

  // R8
  tick_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    sample_tick |-> $past(locked));
endmodule

bind rate_tracker rate_tracker_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .meas_evt(meas_evt), .timeout_evt(timeout_evt),
  .est_upd(est_upd), .locked(locked), .period_est(period_est),
  .domain(domain), .sample_tick(sample_tick), .rate_valid(rate_valid),
  .out_of_range(out_of_range)
);

// File: tb/tb_rate_tracker.sv
`timescale 1ns/1ps
module tb_rate_tracker;
  localparam int REF = 2400;
  localparam int P5  = REF / 5;
  localparam int P12 = REF / 12;
  localparam int P25 = REF / 25;
  localparam int P40 = REF / 40;
  localparam int P55 = REF / 55;
  localparam int TO  = 2 * P5;
  localparam int PW  = $clog2(TO + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic [PW-1:0] period_est;
  logic sample_tick;
  logic [1:0] domain;
  logic rate_valid, out_of_range;

  rate_tracker #(.REF_KHZ(REF)) dut (
    .clk(clk), .rst(rst), .sample_strobe(strobe), .period_est(period_est),
    .sample_tick(sample_tick), .domain(domain), .rate_valid(rate_valid),
    .out_of_range(out_of_range)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, ticks = 0;
  bit done = 0;
  always @(posedge clk) if (sample_tick) ticks++;

  // bench model state
  longint m_prev_t = 0;
  bit m_have = 0, m_estv = 0, m_lock = 0, m_oor = 0;
  int m_est = 0, m_lc = 0, m_dom = 3, m_pend = 3, m_run = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_band(int p);
    int b;
    b = 0;
    if (p < P12 + 1) b = 1;
    if (p < P25 + 1) b = 2;
    if (p < P40 + 1) b = 3;
    return b;
  endfunction

  function automatic int floor16(int d);
    if (d >= 0) return d / 16;
    return -((15 - d) / 16);
  endfunction

  task automatic model_silence();
    if (m_have) begin
      m_have = 0; m_estv = 0; m_lc = 0; m_lock = 0; m_oor = 1; m_run = 0;
    end
  endtask

  task automatic model_strobe(int gap);
    int d, b;
    bit agree;
    if (m_have && gap > TO) model_silence();
    if (!m_have) begin
      m_have = 1;
      return;
    end
    if (!m_estv) begin
      m_est = gap; m_estv = 1; m_lc = 0; m_lock = 0;
    end else begin
      d = gap - m_est;
      agree = ((d < 0 ? -d : d) * 50) <= m_est;
      if (!agree) m_lc = 0;
      else if (m_lc < 16) m_lc++;
      m_lock = (m_lc == 16);
      m_est = m_est + floor16(d);
    end
    m_oor = (m_est < P55) || (m_est > P5);
    if (m_oor) m_run = 0;
    else begin
      b = expect_band(m_est);
      if (b == m_dom) m_run = 0;
      else if (m_run > 0 && b == m_pend) begin
        m_run++;
        if (m_run == 8) begin m_dom = b; m_run = 0; end
      end else begin
        m_pend = b; m_run = 1;
      end
    end
  endtask

  task automatic pulse(int wait_n);
    longint t;
    int gap;
    repeat (wait_n) @(negedge clk);
    strobe = 1'b1;
    t = $time;
    gap = int'((t - m_prev_t) / 10);
    m_prev_t = t;
    @(negedge clk);
    strobe = 1'b0;
    model_strobe(gap);
    repeat (2) @(negedge clk);
    chk("R2 period_est", int'(period_est), m_est);
    chk("R3 rate_valid", int'(rate_valid), int'(m_lock && !m_oor));
    chk("R6 out_of_range", int'(out_of_range), int'(m_oor));
    chk("R5 domain", int'(domain), m_dom);
  endtask

  task automatic run(int p, int j, int n);
    for (int i = 0; i < n; i++) begin
      int g;
      g = p;
      if (j > 0) g = p + int'($urandom_range(2 * j, 0)) - j;
      pulse(g - 3);
    end
  endtask

  task automatic go_silent();
    int snap;
    repeat (TO + 5) @(negedge clk);
    model_silence();
    snap = ticks;
    repeat (40) @(negedge clk);
    chk("R7 out_of_range after silence", int'(out_of_range), 1);
    chk("R7 rate_valid after silence", int'(rate_valid), 0);
    chk("R7 no ticks after silence", ticks - snap, 0);
  endtask

  task automatic tick_spacing();
    longint t1, t2;
    while (!sample_tick) @(negedge clk);
    t1 = $time;
    @(negedge clk);
    while (!sample_tick) @(negedge clk);
    t2 = $time;
    chk("R8 tick spacing", int'((t2 - t1) / 10), int'(period_est));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int snap;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    chk("R9 period_est", int'(period_est), 0);
    chk("R9 domain", int'(domain), 3);
    chk("R9 rate_valid", int'(rate_valid), 0);
    chk("R9 out_of_range", int'(out_of_range), 0);
    chk("R9 sample_tick", int'(sample_tick), 0);

    // R8: 17 strobes are one short of lock, so no tick may appear
    snap = ticks;
    run(50, 0, 17);
    chk("R8 no tick before lock", ticks - snap, 0);
    chk("R3 not valid at 15 agreeing", int'(rate_valid), 0);
    run(50, 0, 1);
    chk("R3 valid at 16 agreeing", int'(rate_valid), 1);
    run(50, 0, 10);
    tick_spacing();

    run(50, 1, 20);
    run(150, 3, 60);
    run(300, 6, 60);
    run(80, 1, 60);
    go_silent();

    // R1 seed and R4 edge at 12 kHz
    pulse(10);
    pulse(197);
    chk("R1 seeded estimate", int'(period_est), 200);
    run(200, 0, 8);
    chk("R4 edge period 200 goes to code 1", int'(domain), 1);
    go_silent();

    // R5 hysteresis: band 0 needs 8 estimates
    pulse(10);
    for (int k = 2; k <= 9; k++) begin
      pulse(198);
      if (k == 8) chk("R5 domain held after 7 estimates", int'(domain), 1);
      if (k == 9) chk("R5 domain moved after 8 estimates", int'(domain), 0);
    end
    go_silent();

    pulse(10);
    run(60, 0, 9);
    chk("R4 edge period 60 goes to code 3", int'(domain), 3);
    go_silent();
    pulse(10);
    run(96, 0, 9);
    chk("R4 edge period 96 goes to code 2", int'(domain), 2);
    go_silent();

    pulse(10);
    run(500, 0, 3);
    chk("R6 slow rate flagged", int'(out_of_range), 1);
    go_silent();
    pulse(10);
    run(40, 0, 3);
    chk("R6 fast rate flagged", int'(out_of_range), 1);
    go_silent();
    pulse(10);
    run(43, 0, 3);
    chk("R6 fastest legal period accepted", int'(out_of_range), 0);

    for (int r = 0; r < 3; r++) begin
      int p;
      p = 45 + int'($urandom_range(420, 0));
      run(p, p / 60, 40);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule